// File: doc/BRIEF.md
# Merged Physical Register State Manager

This block tracks the status of every entry in one physical register file that holds both committed architectural values and speculative renamed values. It holds no data. Each physical register carries a small state machine, and the block also keeps two mapping tables from architectural to physical index. One table is speculative and is written at allocation. The other is committed and is written at retirement.

Issue asks for a register for a destination. The block returns the lowest-numbered free physical register in the same cycle, together with the physical index that the destination mapped to before this allocation. If no register is free, it raises a stall. Execution reports a finished result by physical index. In-order retirement sends back the destination, the new index and the previous index. The new register then becomes architectural purely by a state change, and the previous instance returns to the pool. A cancel pulse discards all speculative work: every renamed register is freed, and the speculative map is rebuilt from the committed map.

The per-register states are exported as a packed vector. Downstream logic uses this vector to see which registers hold valid values.

Top module: `preg_state_mgr`

## Requirements
- R1: After reset, physical registers 0..NUM_ARCH-1 are architectural and all others are free; architectural register d maps to physical register d in both maps.
- R2: `state_vec[2*i+1:2*i]` reports register i: 0 = free, 1 = architectural, 2 = renamed awaiting result, 3 = renamed with result.
- R3: When `alloc_req` is high, a register is free and `cancel` is low, `alloc_gnt` is high in the same cycle and `alloc_phys` is the lowest-indexed free register. That register is in state 2 from the next cycle.
- R4: `alloc_prev` is the physical index most recently mapped to `alloc_arch`, counting earlier allocations that have not retired yet.
- R5: `alloc_stall` is high exactly when `alloc_req` is high and no register is free. A stalled request changes no state.
- R6: A finish notice moves its register from state 2 to state 3. A finish notice aimed at a register in any other state has no effect.
- R7: A completion moves `cmt_phys` from state 3 to architectural and frees `cmt_prev` on the same edge. The number of architectural registers is NUM_ARCH in every cycle.
- R8: A cancel returns every register in state 2 or 3 to free on the next edge. Later allocations then report previous indices taken from the committed map.
- R9: A completion and a cancel in the same cycle apply the completion first, so the completing register stays architectural and its previous instance is freed.
- R10: An allocation request in a cancel cycle is not granted and changes no state.
- R11: A finish notice in a cancel cycle is overridden, and its register becomes free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Issue requests a register for a destination |
| alloc_arch | input | AW | Architectural destination of the request |
| alloc_gnt | output | 1 | Request granted this cycle |
| alloc_stall | output | 1 | Request cannot be served, pool empty |
| alloc_phys | output | PW | Physical register granted |
| alloc_prev | output | PW | Previous physical mapping of the destination |
| fin_vld | input | 1 | Execution result written |
| fin_phys | input | PW | Register whose result was written |
| cmt_vld | input | 1 | Oldest instruction retires |
| cmt_arch | input | AW | Its architectural destination |
| cmt_phys | input | PW | Its physical register |
| cmt_prev | input | PW | Previous instance to reclaim |
| cancel | input | 1 | Discard all speculative state |
| state_vec | output | 2*NUM_PHYS | Packed per-register state codes |

## Verification
The assertions check the following in every cycle: the architectural count stays constant, a grant lands in the awaiting state, a finish moves a waiting register to ready, a stall only occurs on an empty pool, and a cancel empties both rename states while suppressing grants. The ordering effects need the bench's scenarios, which run a reference model against the design. These effects are lowest-index selection across a fragmented pool, previous-index chains through repeated renames of one destination, map restoration after a cancel, and the combined completion-with-cancel edge.

// File: rtl/prsm_pkg.sv
package prsm_pkg;

    typedef enum logic [1:0] {
        PS_FREE  = 2'd0,
        PS_ARCH  = 2'd1,
        PS_WAIT  = 2'd2,
        PS_READY = 2'd3
    } preg_state_e;

endpackage

// File: rtl/prsm_cell.sv
module prsm_cell
    import prsm_pkg::*;
#(
    parameter bit INIT_ARCH = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic        fin,
    input  logic        promote,
    input  logic        retire_old,
    input  logic        flush,
    output preg_state_e state_o
);

    preg_state_e cur_q;
    preg_state_e nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= INIT_ARCH ? PS_ARCH : PS_FREE;
        end else begin
            cur_q <= nxt;
        end
    end

    // transitions: completion is evaluated ahead of flush
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            PS_FREE: begin
                if (take) nxt = PS_WAIT;
            end
            PS_WAIT: begin
                if (flush)    nxt = PS_FREE;
                else if (fin) nxt = PS_READY;
            end
            PS_READY: begin
                if (promote)    nxt = PS_ARCH;
                else if (flush) nxt = PS_FREE;
            end
            PS_ARCH: begin
                if (retire_old) nxt = PS_FREE;
            end
            default: nxt = PS_FREE;
        endcase
    end

    // output process
    always_comb begin
        state_o = cur_q;
    end

endmodule

// File: rtl/prsm_pick.sv
module prsm_pick #(
    parameter int unsigned N  = 64,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  free_vec,
    output logic          any_free,
    output logic [IW-1:0] idx
);

    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (free_vec[k]) begin
                any_free = 1'b1;
                idx      = IW'(k);
            end
        end
    end

endmodule

// File: rtl/prsm_maptab.sv
module prsm_maptab #(
    parameter int unsigned NA = 32,
    parameter int unsigned NP = 64,
    localparam int unsigned AW = $clog2(NA),
    localparam int unsigned PW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_arch,
    input  logic [PW-1:0] wr_phys,
    input  logic [AW-1:0] rd_arch,
    output logic [PW-1:0] rd_phys,
    input  logic          cmt_en,
    input  logic [AW-1:0] cmt_arch,
    input  logic [PW-1:0] cmt_phys,
    input  logic          flush
);

    logic [PW-1:0] spec_q [NA];
    logic [PW-1:0] cmt_q  [NA];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NA); i++) begin
                spec_q[i] <= PW'(i);
                cmt_q[i]  <= PW'(i);
            end
        end else begin
            if (cmt_en) begin
                cmt_q[cmt_arch] <= cmt_phys;
            end
            if (flush) begin
                // rebuild from the committed map including this cycle's retirement
                for (int i = 0; i < int'(NA); i++) begin
                    spec_q[i] <= (cmt_en && cmt_arch == AW'(i)) ? cmt_phys : cmt_q[i];
                end
            end else if (wr_en) begin
                spec_q[wr_arch] <= wr_phys;
            end
        end
    end

    assign rd_phys = spec_q[rd_arch];

endmodule

// File: rtl/preg_state_mgr.sv
module preg_state_mgr
    import prsm_pkg::*;
#(
    parameter int unsigned NUM_ARCH = 32,
    parameter int unsigned NUM_PHYS = 64,
    localparam int unsigned AW = $clog2(NUM_ARCH),
    localparam int unsigned PW = $clog2(NUM_PHYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_req,
    input  logic [AW-1:0]         alloc_arch,
    output logic                  alloc_gnt,
    output logic                  alloc_stall,
    output logic [PW-1:0]         alloc_phys,
    output logic [PW-1:0]         alloc_prev,
    input  logic                  fin_vld,
    input  logic [PW-1:0]         fin_phys,
    input  logic                  cmt_vld,
    input  logic [AW-1:0]         cmt_arch,
    input  logic [PW-1:0]         cmt_phys,
    input  logic [PW-1:0]         cmt_prev,
    input  logic                  cancel,
    output logic [2*NUM_PHYS-1:0] state_vec
);

    logic [NUM_PHYS-1:0] free_vec;
    logic                any_free;
    logic [PW-1:0]       pick_idx;

    genvar gi;
    generate
        for (gi = 0; gi < int'(NUM_PHYS); gi++) begin : g_cell
            preg_state_e st;
            logic take_w, fin_w, pro_w, old_w;

            assign take_w = alloc_gnt && (pick_idx == PW'(gi));
            assign fin_w  = fin_vld   && (fin_phys == PW'(gi));
            assign pro_w  = cmt_vld   && (cmt_phys == PW'(gi));
            assign old_w  = cmt_vld   && (cmt_prev == PW'(gi));

            prsm_cell #(
                .INIT_ARCH(gi < int'(NUM_ARCH))
            ) u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .take       (take_w),
                .fin        (fin_w),
                .promote    (pro_w),
                .retire_old (old_w),
                .flush      (cancel),
                .state_o    (st)
            );

            assign free_vec[gi]         = (st == PS_FREE);
            assign state_vec[2*gi +: 2] = st;
        end
    endgenerate

    prsm_pick #(
        .N  (NUM_PHYS),
        .IW (PW)
    ) u_pick (
        .free_vec (free_vec),
        .any_free (any_free),
        .idx      (pick_idx)
    );

    assign alloc_gnt   = alloc_req && any_free && !cancel;
    assign alloc_stall = alloc_req && !any_free;
    assign alloc_phys  = pick_idx;

    prsm_maptab #(
        .NA (NUM_ARCH),
        .NP (NUM_PHYS)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (alloc_gnt),
        .wr_arch  (alloc_arch),
        .wr_phys  (pick_idx),
        .rd_arch  (alloc_arch),
        .rd_phys  (alloc_prev),
        .cmt_en   (cmt_vld),
        .cmt_arch (cmt_arch),
        .cmt_phys (cmt_phys),
        .flush    (cancel)
    );

endmodule

// File: rtl/prsm_chk.sv
module prsm_chk #(
    parameter int unsigned NUM_ARCH = 32,
    parameter int unsigned NUM_PHYS = 64,
    localparam int unsigned PW = $clog2(NUM_PHYS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  alloc_gnt,
    input logic                  alloc_stall,
    input logic [PW-1:0]         alloc_phys,
    input logic                  fin_vld,
    input logic [PW-1:0]         fin_phys,
    input logic                  cancel,
    input logic [2*NUM_PHYS-1:0] state_vec
);

    int arch_n, free_n, ren_n;

    always_comb begin
        arch_n = 0;
        free_n = 0;
        ren_n  = 0;
        for (int i = 0; i < int'(NUM_PHYS); i++) begin
            if (state_vec[2*i +: 2] == 2'd1) arch_n++;
            if (state_vec[2*i +: 2] == 2'd0) free_n++;
            if (state_vec[2*i + 1])          ren_n++;
        end
    end

    function automatic logic [1:0] st_at(input logic [PW-1:0] p);
        return state_vec[2*p +: 2];
    endfunction

    a_r7_arch_count: assert property (@(posedge clk) disable iff (!rst_n)
        arch_n == int'(NUM_ARCH));

    a_r3_pick_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |-> st_at(alloc_phys) == 2'd0);

    a_r3_alloc_wait: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |=> st_at($past(alloc_phys)) == 2'd2);

    a_r5_stall_empty: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_stall |-> (free_n == 0 && !alloc_gnt));

    a_r6_finish_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_vld && !cancel && st_at(fin_phys) == 2'd2) |=> st_at($past(fin_phys)) == 2'd3);

    a_r8_cancel_flush: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> ren_n == 0);

    a_r10_no_grant_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |-> !alloc_gnt);

endmodule

bind preg_state_mgr prsm_chk #(
    .NUM_ARCH (NUM_ARCH),
    .NUM_PHYS (NUM_PHYS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_gnt   (alloc_gnt),
    .alloc_stall (alloc_stall),
    .alloc_phys  (alloc_phys),
    .fin_vld     (fin_vld),
    .fin_phys    (fin_phys),
    .cancel      (cancel),
    .state_vec   (state_vec)
);

// File: tb/sim_preg_state_mgr.sv
module sim_preg_state_mgr;

    localparam int CLK_PERIOD = 10;
    localparam int NA = 32;
    localparam int NP = 64;
    localparam int AW = 5;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_req = 1'b0;
    logic [AW-1:0] alloc_arch = '0;
    logic          alloc_gnt, alloc_stall;
    logic [PW-1:0] alloc_phys, alloc_prev;
    logic          fin_vld = 1'b0;
    logic [PW-1:0] fin_phys = '0;
    logic          cmt_vld = 1'b0;
    logic [AW-1:0] cmt_arch = '0;
    logic [PW-1:0] cmt_phys = '0;
    logic [PW-1:0] cmt_prev = '0;
    logic          cancel = 1'b0;
    logic [2*NP-1:0] state_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    preg_state_mgr #(.NUM_ARCH(NA), .NUM_PHYS(NP)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_arch(alloc_arch),
        .alloc_gnt(alloc_gnt), .alloc_stall(alloc_stall),
        .alloc_phys(alloc_phys), .alloc_prev(alloc_prev),
        .fin_vld(fin_vld), .fin_phys(fin_phys),
        .cmt_vld(cmt_vld), .cmt_arch(cmt_arch),
        .cmt_phys(cmt_phys), .cmt_prev(cmt_prev),
        .cancel(cancel), .state_vec(state_vec)
    );

    // reference model
    int m_st [NP];
    int m_spec [NA];
    int m_cmt [NA];
    int q_dst [NP];
    int q_ph [NP];
    int q_pv [NP];
    int qh = 0;
    int qn = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < NP; i++) if (m_st[i] == 0) return i;
        return -1;
    endfunction

    task automatic check_state(string tag);
        int bad;
        int cnt;
        bad = -1;
        cnt = 0;
        for (int i = 0; i < NP; i++) begin
            if (int'(state_vec[2*i +: 2]) != m_st[i] && bad < 0) bad = i;
            if (state_vec[2*i +: 2] == 2'd1) cnt++;
        end
        n_run++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s R2 state of reg %0d actual=%0d expected=%0d",
                     tag, bad, state_vec[2*bad +: 2], m_st[bad]);
        end
        chk({tag, " R7 arch count"}, cnt, NA);
    endtask

    task automatic step(bit a, int dst, bit f, int fp, bit c, bit x, string tag);
        int  lf;
        bit  cmt_ok, eg, es, fin_hit;
        cmt_ok = c && qn > 0 && m_st[q_ph[qh]] == 3;
        alloc_req  = a;
        alloc_arch = AW'(dst);
        fin_vld    = f;
        fin_phys   = PW'(fp);
        cmt_vld    = cmt_ok;
        cmt_arch   = cmt_ok ? AW'(q_dst[qh]) : '0;
        cmt_phys   = cmt_ok ? PW'(q_ph[qh]) : '0;
        cmt_prev   = cmt_ok ? PW'(q_pv[qh]) : '0;
        cancel     = x;
        #1;
        lf = lowest_free();
        eg = a && lf >= 0 && !x;
        es = a && lf < 0;
        chk({tag, " R5 stall"}, int'(alloc_stall), int'(es));
        chk({tag, " R10 grant"}, int'(alloc_gnt), int'(eg));
        if (eg) begin
            chk({tag, " R3 phys"}, int'(alloc_phys), lf);
            chk({tag, " R4 prev"}, int'(alloc_prev), m_spec[dst]);
        end
        fin_hit = f && !x && m_st[fp] == 2;
        if (cmt_ok) begin
            m_st[q_ph[qh]] = 1;
            m_st[q_pv[qh]] = 0;
            m_cmt[q_dst[qh]] = q_ph[qh];
            qh = (qh + 1) % NP;
            qn--;
        end
        if (fin_hit) m_st[fp] = 3;
        if (eg) begin
            m_st[lf] = 2;
            q_dst[(qh + qn) % NP] = dst;
            q_ph[(qh + qn) % NP]  = lf;
            q_pv[(qh + qn) % NP]  = m_spec[dst];
            qn++;
            m_spec[dst] = lf;
        end
        if (x) begin
            for (int i = 0; i < NP; i++) if (m_st[i] >= 2) m_st[i] = 0;
            for (int i = 0; i < NA; i++) m_spec[i] = m_cmt[i];
            qn = 0;
        end
        @(negedge clk);
        check_state(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        for (int i = 0; i < NP; i++) m_st[i] = (i < NA) ? 1 : 0;
        for (int i = 0; i < NA; i++) begin
            m_spec[i] = i;
            m_cmt[i]  = i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_state("R1 reset");

        // directed corner cases
        step(1, 5, 0, 0, 0, 0, "R1 R3 first alloc");
        step(1, 5, 0, 0, 0, 0, "R4 rename chain");
        step(0, 0, 1, 33, 0, 0, "R6 finish young");
        step(0, 0, 1, 0, 0, 0, "R6 finish on arch ignored");
        step(0, 0, 1, 33, 0, 0, "R6 finish on ready ignored");
        step(0, 0, 1, 32, 0, 0, "R6 finish old");
        step(0, 0, 0, 0, 1, 1, "R9 commit with cancel");
        step(1, 5, 0, 0, 0, 0, "R8 map restored");
        step(1, 7, 0, 0, 0, 1, "R10 alloc with cancel");
        step(1, 9, 0, 0, 0, 0, "R3 refill");
        step(0, 0, 1, 5, 0, 1, "R11 finish with cancel");
        for (int i = 0; i < 36; i++) step(1, i % NA, 0, 0, 0, 0, "R5 fill pool");
        step(0, 0, 0, 0, 0, 1, "R8 flush full");

        // constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            bit a, f, c, x;
            int dst, fp;
            a   = ($urandom % 100) < 55;
            dst = $urandom % NA;
            f   = ($urandom % 100) < 50;
            fp  = $urandom % NP;
            if (f && qn > 0 && ($urandom % 100) < 85)
                fp = q_ph[(qh + ($urandom % qn)) % NP];
            c   = ($urandom % 100) < 45;
            x   = ($urandom % 100) < 3;
            step(a, dst, f, fp, c, x, "R3 R6 R7 R8 random");
        end

        alloc_req = 1'b0;
        fin_vld   = 1'b0;
        cmt_vld   = 1'b0;
        cancel    = 1'b0;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule